// File: doc/BRIEF.md
# Byte-Oriented Serial Port with Host Flags

This block is a full-duplex asynchronous serial port for an embedded controller. A host writes a byte to start a frame on the transmit line and reads the most recently accepted received byte from a holding buffer. Static control inputs select the frame length, gate the receiver, request a stop-bit validity check, and supply the extra data bit sent in long frames. Two sticky flags report a finished transmission and an accepted reception. Each flag is cleared by its own host strobe. An interrupt request combines both flags under an enable.

An external oversampling tick, `OVS` pulses per bit time, paces both directions. The transmitter holds each bit for `OVS` ticks. The receiver synchronises the line, waits for a falling edge, confirms the start bit at its middle and then samples each later bit at its centre. A short frame carries a start bit, the data bits least significant first and a stop bit. A long frame adds one extra data bit before the stop bit.

Top module: `sport_uart`

## Requirements
- R1: With `mode9`=0, one host write sends 10 bit times: a low start bit, the 8 data bits least significant first, and a high stop bit. While no frame is in progress, `txd` stays high.
- R2: With `mode9`=1, the frame is 11 bit times. The ninth bit, placed between data bit 7 and the stop bit, equals `tx_bit9` at the time of the write.
- R3: `tx_flag` is 0 during the last data-carrying bit and is already 1 at the middle of the stop bit.
- R4: A host write made while a frame is still being sent has no effect. The frame in progress completes unchanged and no second frame follows.
- R5: With `mode9`=0, an accepted frame loads `rd_data` with the data byte, sets `rx_bit9` to the received stop bit, and sets `rx_flag`.
- R6: With `mode9`=1, `rx_bit9` takes the received ninth bit and the stop-bit value is not stored.
- R7: A frame that ends while `rx_flag` is 1 leaves `rd_data`, `rx_bit9` and `rx_flag` unchanged. The older byte is kept.
- R8: When `mp_chk`=1, a frame whose stop bit is 0 updates nothing. When `mp_chk`=0, the same frame is accepted.
- R9: While `rx_en`=0, frames on `rxd` are not received.
- R10: A low pulse on `rxd` that has returned high by the middle of the start bit is discarded.
- R11: Each flag stays set until its clear strobe. If a set and a clear of the same flag land in the same cycle, the set wins and the flag is high for that one cycle.
- R12: `irq` is 1 exactly when `irq_en` is 1 and at least one of `tx_flag` and `rx_flag` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversampling tick, OVS per bit time |
| wr_data | input | 1 | Host write strobe, starts a frame |
| wdata | input | DATA_W | Byte to transmit |
| mode9 | input | 1 | 0: short frame, 1: frame with ninth bit |
| rx_en | input | 1 | Receiver enable |
| mp_chk | input | 1 | Require a high stop bit for acceptance |
| tx_bit9 | input | 1 | Ninth bit to send in long frames |
| irq_en | input | 1 | Interrupt enable |
| clr_tx_flag | input | 1 | Clear strobe for tx_flag |
| clr_rx_flag | input | 1 | Clear strobe for rx_flag |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idle high |
| rd_data | output | DATA_W | Received byte buffer |
| rx_bit9 | output | 1 | Received ninth bit or stop bit |
| tx_flag | output | 1 | Transmit-done flag |
| rx_flag | output | 1 | Receive-done flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardware setting of a flag and the host clearing of the same flag can fall in the same cycle. The bench provokes this collision without knowing the exact internal cycle. It holds the clear strobe high for a whole transmitted frame, and again for a whole received frame, and counts the sampled cycles in which the flag reads 1. Under set-wins priority the count must be exactly one. In the receive case, the byte must also have been loaded, which shows the set was not lost to the clear.

// File: rtl/sport_pkg.sv
package sport_pkg;
   localparam int unsigned SPORT_DEF_DATA_W = 8;
   localparam int unsigned SPORT_DEF_OVS    = 16;
   localparam int unsigned SPORT_DEF_SYNC   = 2;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_BITS  = 2'd2
   } rx_state_t;
endpackage

// File: rtl/sport_tx.sv
module sport_tx #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              mode9,
   input  logic              bit9,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              txd,
   output logic              busy,
   output logic              stop_go
);
   localparam int unsigned FRAME_MAX = DATA_W + 3;
   localparam int unsigned CNT_W     = $clog2(FRAME_MAX + 1);
   localparam int unsigned TICK_W    = $clog2(OVS);

   logic [FRAME_MAX-1:0] sh_q;
   logic [CNT_W-1:0]     idx_q;
   logic [CNT_W-1:0]     last_q;
   logic [TICK_W-1:0]    tcnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         sh_q    <= '1;
         idx_q   <= '0;
         last_q  <= '0;
         tcnt_q  <= '0;
         stop_go <= 1'b0;
      end else begin
         stop_go <= 1'b0;
         if (!busy) begin
            if (wr) begin
               busy   <= 1'b1;
               tcnt_q <= '0;
               idx_q  <= '0;
               if (mode9) begin
                  sh_q   <= {1'b1, bit9, wdata, 1'b0};
                  last_q <= CNT_W'(DATA_W + 2);
               end else begin
                  sh_q   <= {1'b1, 1'b1, wdata, 1'b0};
                  last_q <= CNT_W'(DATA_W + 1);
               end
            end
         end else if (os_tick) begin
            if (tcnt_q == TICK_W'(OVS - 1)) begin
               tcnt_q <= '0;
               if (idx_q == last_q) begin
                  busy <= 1'b0;
               end else begin
                  sh_q  <= {1'b1, sh_q[FRAME_MAX-1:1]};
                  idx_q <= idx_q + 1'b1;
                  if (idx_q + 1'b1 == last_q) stop_go <= 1'b1;
               end
            end else begin
               tcnt_q <= tcnt_q + 1'b1;
            end
         end
      end
   end

   assign txd = busy ? sh_q[0] : 1'b1;
endmodule

// File: rtl/sport_rx.sv
module sport_rx
   import sport_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OVS    = 16,
   parameter int unsigned SYNC_N = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              rx_en,
   input  logic              mode9,
   input  logic              rxd,
   output logic              done,
   output logic [DATA_W-1:0] data,
   output logic              ninth,
   output logic              stop
);
   localparam int unsigned CNT_W  = $clog2(DATA_W + 3);
   localparam int unsigned TICK_W = $clog2(OVS);
   localparam int unsigned HALF   = OVS / 2;

   logic [SYNC_N-1:0] sync_q;
   logic              rx_s;
   logic              prev_q;
   rx_state_t         st_q;
   logic [TICK_W-1:0] tcnt_q;
   logic [CNT_W-1:0]  idx_q;
   logic [CNT_W-1:0]  last_q;
   logic              long_q;
   logic              bit9_q;

   generate
      if (SYNC_N == 1) begin : g_sync_one
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= rxd;
         end
      end else begin : g_sync_chain
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_N-2:0], rxd};
         end
      end
   endgenerate

   assign rx_s = sync_q[SYNC_N-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
         st_q   <= RX_IDLE;
         tcnt_q <= '0;
         idx_q  <= '0;
         last_q <= '0;
         long_q <= 1'b0;
         bit9_q <= 1'b0;
         data   <= '0;
         stop   <= 1'b0;
         done   <= 1'b0;
      end else begin
         prev_q <= rx_s;
         done   <= 1'b0;
         if (!rx_en) begin
            st_q <= RX_IDLE;
         end else begin
            unique case (st_q)
               RX_IDLE: begin
                  if (prev_q && !rx_s) begin
                     st_q   <= RX_START;
                     tcnt_q <= '0;
                     long_q <= mode9;
                     last_q <= mode9 ? CNT_W'(DATA_W + 1) : CNT_W'(DATA_W);
                  end
               end
               RX_START: begin
                  if (os_tick) begin
                     if (tcnt_q == TICK_W'(HALF - 1)) begin
                        tcnt_q <= '0;
                        idx_q  <= '0;
                        st_q   <= rx_s ? RX_IDLE : RX_BITS;
                     end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                     end
                  end
               end
               RX_BITS: begin
                  if (os_tick) begin
                     if (tcnt_q == TICK_W'(OVS - 1)) begin
                        tcnt_q <= '0;
                        idx_q  <= idx_q + 1'b1;
                        if (idx_q < CNT_W'(DATA_W)) begin
                           data <= {rx_s, data[DATA_W-1:1]};
                        end else if (idx_q == last_q) begin
                           stop <= rx_s;
                           done <= 1'b1;
                           st_q <= RX_IDLE;
                        end else begin
                           bit9_q <= rx_s;
                        end
                     end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                     end
                  end
               end
               default: st_q <= RX_IDLE;
            endcase
         end
      end
   end

   assign ninth = long_q ? bit9_q : stop;
endmodule

// File: rtl/sport_flags.sv
module sport_flags #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_set,
   input  logic              rx_done,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_ninth,
   input  logic              rx_stop,
   input  logic              mp_chk,
   input  logic              clr_tx,
   input  logic              clr_rx,
   input  logic              irq_en,
   output logic              tx_flag,
   output logic              rx_flag,
   output logic [DATA_W-1:0] rx_buf,
   output logic              rx_bit9,
   output logic              irq
);
   logic accept;

   assign accept = rx_done && !rx_flag && (!mp_chk || rx_stop);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_flag <= 1'b0;
         rx_flag <= 1'b0;
         rx_buf  <= '0;
         rx_bit9 <= 1'b0;
      end else begin
         if (tx_set)      tx_flag <= 1'b1;
         else if (clr_tx) tx_flag <= 1'b0;
         if (accept) begin
            rx_flag <= 1'b1;
            rx_buf  <= rx_data;
            rx_bit9 <= rx_ninth;
         end else if (clr_rx) begin
            rx_flag <= 1'b0;
         end
      end
   end

   assign irq = irq_en && (tx_flag || rx_flag);
endmodule

// File: rtl/sport_uart.sv
module sport_uart #(
   parameter int unsigned DATA_W = sport_pkg::SPORT_DEF_DATA_W,
   parameter int unsigned OVS    = sport_pkg::SPORT_DEF_OVS,
   parameter int unsigned SYNC_N = sport_pkg::SPORT_DEF_SYNC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              wr_data,
   input  logic [DATA_W-1:0] wdata,
   input  logic              mode9,
   input  logic              rx_en,
   input  logic              mp_chk,
   input  logic              tx_bit9,
   input  logic              irq_en,
   input  logic              clr_tx_flag,
   input  logic              clr_rx_flag,
   input  logic              rxd,
   output logic              txd,
   output logic [DATA_W-1:0] rd_data,
   output logic              rx_bit9,
   output logic              tx_flag,
   output logic              rx_flag,
   output logic              irq
);
   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("sport_uart: OVS must be even and at least 4");
      end
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
         $error("sport_uart: DATA_W must be between 5 and 9");
      end
      if (SYNC_N < 1 || SYNC_N > 4) begin : g_bad_sync
         $error("sport_uart: SYNC_N must be between 1 and 4");
      end
   endgenerate

   logic              tx_busy;
   logic              tx_stop_go;
   logic              rx_done;
   logic [DATA_W-1:0] rx_data;
   logic              rx_ninth;
   logic              rx_stop;

   sport_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .mode9(mode9),
      .bit9(tx_bit9), .wr(wr_data), .wdata(wdata), .txd(txd),
      .busy(tx_busy), .stop_go(tx_stop_go)
   );

   sport_rx #(.DATA_W(DATA_W), .OVS(OVS), .SYNC_N(SYNC_N)) u_rx (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_en(rx_en),
      .mode9(mode9), .rxd(rxd), .done(rx_done), .data(rx_data),
      .ninth(rx_ninth), .stop(rx_stop)
   );

   sport_flags #(.DATA_W(DATA_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .tx_set(tx_stop_go), .rx_done(rx_done),
      .rx_data(rx_data), .rx_ninth(rx_ninth), .rx_stop(rx_stop),
      .mp_chk(mp_chk), .clr_tx(clr_tx_flag), .clr_rx(clr_rx_flag),
      .irq_en(irq_en), .tx_flag(tx_flag), .rx_flag(rx_flag),
      .rx_buf(rd_data), .rx_bit9(rx_bit9), .irq(irq)
   );
endmodule

// File: rtl/sport_uart_chk.sv
module sport_uart_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_data,
   input logic              clr_tx_flag,
   input logic              tx_busy,
   input logic              txd,
   input logic              tx_flag,
   input logic              rx_flag,
   input logic [DATA_W-1:0] rd_data,
   input logic              irq
);
   assert_start_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && !tx_busy) |=> !txd);

   assert_stop_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_flag) |-> txd);

   assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && tx_busy) |=> (tx_busy || txd));

   assert_keep_old_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flag |=> $stable(rd_data));

   assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_flag && !clr_tx_flag) |=> tx_flag);

   assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_flag && !rx_flag) |-> !irq);
endmodule

bind sport_uart sport_uart_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .clr_tx_flag(clr_tx_flag),
   .tx_busy(tx_busy), .txd(txd), .tx_flag(tx_flag), .rx_flag(rx_flag),
   .rd_data(rd_data), .irq(irq)
);

// File: tb/sport_uart_tb.sv
module sport_uart_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b1;
   logic       wr_data = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic       mode9 = 1'b0;
   logic       rx_en = 1'b0;
   logic       mp_chk = 1'b0;
   logic       tx_bit9 = 1'b0;
   logic       irq_en = 1'b0;
   logic       clr_tx_flag = 1'b0;
   logic       clr_rx_flag = 1'b0;
   logic       rxd = 1'b1;
   logic       txd;
   logic [7:0] rd_data;
   logic       rx_bit9, tx_flag, rx_flag, irq;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   sport_uart u_dut (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .wr_data(wr_data),
      .wdata(wdata), .mode9(mode9), .rx_en(rx_en), .mp_chk(mp_chk),
      .tx_bit9(tx_bit9), .irq_en(irq_en), .clr_tx_flag(clr_tx_flag),
      .clr_rx_flag(clr_rx_flag), .rxd(rxd), .txd(txd), .rd_data(rd_data),
      .rx_bit9(rx_bit9), .tx_flag(tx_flag), .rx_flag(rx_flag), .irq(irq)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic host_write(input logic [7:0] d);
      @(negedge clk); wr_data = 1'b1; wdata = d;
      @(negedge clk); wr_data = 1'b0;
   endtask

   task automatic clear_tx();
      @(negedge clk); clr_tx_flag = 1'b1;
      @(negedge clk); clr_tx_flag = 1'b0;
   endtask

   task automatic clear_rx();
      @(negedge clk); clr_rx_flag = 1'b1;
      @(negedge clk); clr_rx_flag = 1'b0;
   endtask

   task automatic tx_capture(input int nbits, output logic [10:0] bits,
                             output logic fl_last, output logic fl_stop);
      int guard = 0;
      bits = '0; fl_last = 1'b0; fl_stop = 1'b0;
      @(negedge clk);
      while (txd && guard < 500) begin @(negedge clk); guard++; end
      repeat (8) @(negedge clk);
      bits[0] = txd;
      for (int i = 1; i < nbits; i++) begin
         repeat (16) @(negedge clk);
         bits[i] = txd;
         if (i == nbits - 2) fl_last = tx_flag;
         if (i == nbits - 1) fl_stop = tx_flag;
      end
   endtask

   task automatic rx_send(input logic [7:0] d, input bit nine, input bit b9, input bit sb);
      @(negedge clk); rxd = 1'b0;
      repeat (16) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd = d[i];
         repeat (16) @(negedge clk);
      end
      if (nine) begin
         rxd = b9;
         repeat (16) @(negedge clk);
      end
      rxd = sb;
      repeat (16) @(negedge clk);
      rxd = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   // R1: 8-bit transmit frame
   task automatic t_tx8();
      logic [10:0] b; logic fa, fb;
      mode9 = 1'b0;
      fork
         host_write(8'hA5);
         tx_capture(10, b, fa, fb);
      join
      check(b[0] == 1'b0, "R1 start bit", b[0], 0);
      check(b[8:1] == 8'hA5, "R1 data lsb first", b[8:1], 8'hA5);
      check(b[9] == 1'b1, "R1 stop bit", b[9], 1);
      check(fa == 1'b0, "R3 flag low in last data bit", fa, 0);
      check(fb == 1'b1, "R3 flag high in stop bit", fb, 1);
      repeat (20) @(negedge clk);
      check(txd == 1'b1, "R1 idle high", txd, 1);
   endtask

   // R2: 9-bit transmit frame
   task automatic t_tx9();
      logic [10:0] b; logic fa, fb;
      mode9 = 1'b1; tx_bit9 = 1'b1;
      clear_tx();
      fork
         host_write(8'h3C);
         tx_capture(11, b, fa, fb);
      join
      check(b[8:1] == 8'h3C, "R2 data", b[8:1], 8'h3C);
      check(b[9] == 1'b1, "R2 ninth bit", b[9], 1);
      check(b[10] == 1'b1, "R2 stop bit", b[10], 1);
      check(fa == 1'b0 && fb == 1'b1, "R3 flag at stop start 9-bit", {fa, fb}, 1);
      mode9 = 1'b0; tx_bit9 = 1'b0;
      repeat (20) @(negedge clk);
   endtask

   // R4: write during a frame is ignored
   task automatic t_busy_write();
      logic [10:0] b; logic fa, fb; int lows;
      clear_tx();
      fork
         begin
            host_write(8'h55);
            repeat (40) @(negedge clk);
            host_write(8'hFF);
         end
         tx_capture(10, b, fa, fb);
      join
      check(b[8:1] == 8'h55, "R4 frame unchanged", b[8:1], 8'h55);
      lows = 0;
      repeat (200) begin
         @(negedge clk);
         if (!txd) lows++;
      end
      check(lows == 0, "R4 no second frame", lows, 0);
   endtask

   // R12: interrupt combine
   task automatic t_irq_tx();
      irq_en = 1'b1; @(negedge clk);
      check(irq == 1'b1, "R12 irq with tx_flag", irq, 1);
      irq_en = 1'b0; @(negedge clk);
      check(irq == 1'b0, "R12 irq masked", irq, 0);
      irq_en = 1'b1;
      clear_tx();
      check(tx_flag == 1'b0, "R11 tx clear", tx_flag, 0);
      check(irq == 1'b0, "R12 irq drops with flags", irq, 0);
   endtask

   // R11: tx set and clear collide
   task automatic t_tx_collide();
      int highs = 0;
      @(negedge clk); clr_tx_flag = 1'b1;
      host_write(8'h0F);
      repeat (220) begin
         @(negedge clk);
         if (tx_flag) highs++;
      end
      clr_tx_flag = 1'b0;
      check(highs == 1, "R11 set wins over clear (tx)", highs, 1);
   endtask

   // R5, R7, R8, R6, R9, R10
   task automatic t_rx8();
      rx_en = 1'b1; mode9 = 1'b0; mp_chk = 1'b0;
      rx_send(8'h96, 0, 0, 1);
      check(rd_data == 8'h96, "R5 rx data", rd_data, 8'h96);
      check(rx_bit9 == 1'b1, "R5 stop stored", rx_bit9, 1);
      check(rx_flag == 1'b1, "R5 rx flag", rx_flag, 1);
      check(irq == 1'b1, "R12 irq with rx_flag", irq, 1);
   endtask

   task automatic t_overrun();
      rx_send(8'h11, 0, 0, 0);
      check(rd_data == 8'h96, "R7 older byte kept", rd_data, 8'h96);
      check(rx_bit9 == 1'b1, "R7 bit9 kept", rx_bit9, 1);
      check(rx_flag == 1'b1, "R11 rx flag sticky", rx_flag, 1);
      clear_rx();
      check(rx_flag == 1'b0, "R11 rx clear", rx_flag, 0);
   endtask

   task automatic t_mpchk();
      mp_chk = 1'b1;
      rx_send(8'h22, 0, 0, 0);
      check(rx_flag == 1'b0, "R8 bad stop no flag", rx_flag, 0);
      check(rd_data == 8'h96, "R8 bad stop no load", rd_data, 8'h96);
      mp_chk = 1'b0;
      rx_send(8'h22, 0, 0, 0);
      check(rd_data == 8'h22 && rx_flag, "R8 accepted without check", rd_data, 8'h22);
      check(rx_bit9 == 1'b0, "R5 low stop stored", rx_bit9, 0);
      clear_rx();
   endtask

   task automatic t_rx9();
      mode9 = 1'b1;
      rx_send(8'h5A, 1, 1, 0);
      check(rd_data == 8'h5A, "R6 rx data 9-bit", rd_data, 8'h5A);
      check(rx_bit9 == 1'b1, "R6 ninth stored", rx_bit9, 1);
      clear_rx();
      rx_send(8'hC3, 1, 0, 1);
      check(rx_bit9 == 1'b0, "R6 stop ignored", rx_bit9, 0);
      check(rd_data == 8'hC3 && rx_flag, "R6 second frame", rd_data, 8'hC3);
      clear_rx();
      mode9 = 1'b0;
   endtask

   task automatic t_rx_disabled();
      rx_en = 1'b0;
      rx_send(8'h77, 0, 0, 1);
      check(rx_flag == 1'b0, "R9 no flag when disabled", rx_flag, 0);
      check(rd_data == 8'hC3, "R9 buffer untouched", rd_data, 8'hC3);
      rx_en = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   task automatic t_glitch();
      @(negedge clk); rxd = 1'b0;
      repeat (3) @(negedge clk);
      rxd = 1'b1;
      repeat (200) @(negedge clk);
      check(rx_flag == 1'b0, "R10 glitch no flag", rx_flag, 0);
      check(rd_data == 8'hC3, "R10 glitch no load", rd_data, 8'hC3);
      rx_send(8'h81, 0, 0, 1);
      check(rd_data == 8'h81, "R10 receiver recovers", rd_data, 8'h81);
      clear_rx();
   endtask

   task automatic t_rx_collide();
      int highs = 0;
      @(negedge clk); clr_rx_flag = 1'b1;
      fork
         rx_send(8'h6E, 0, 0, 1);
         repeat (200) begin
            @(negedge clk);
            if (rx_flag) highs++;
         end
      join
      clr_rx_flag = 1'b0;
      check(highs == 1, "R11 set wins over clear (rx)", highs, 1);
      check(rd_data == 8'h6E, "R11 byte loaded during clear", rd_data, 8'h6E);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(txd == 1'b1, "R1 reset txd", txd, 1);
      check(!tx_flag && !rx_flag, "R11 reset flags", {tx_flag, rx_flag}, 0);
      check(rd_data == 8'h00 && !rx_bit9, "R5 reset buffer", rd_data, 0);
      check(irq == 1'b0, "R12 reset irq", irq, 0);
      t_tx8();
      t_tx9();
      t_busy_write();
      t_irq_tx();
      t_tx_collide();
      t_rx8();
      t_overrun();
      t_mpchk();
      t_rx9();
      t_rx_disabled();
      t_glitch();
      t_rx_collide();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule